// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus whose data line is stuck low because a target lost track of where it was in a byte. When asked, it plays one fixed waveform on the clock and data lines: a start condition, a released data line with nine clock pulses, a second start condition, and then a stop condition. The stop leaves both lines released and idle. Both lines are open drain. The block only ever pulls a line low or lets it go.

Every delay is a whole number of periods of a one-microsecond enable pulse, `us_tick`. Each delay length is a parameter. When the block releases the clock line, it waits for the line to read high, so a target that stretches the clock is respected. A cap on this wait keeps a clock line that is held low for good from hanging the sequence. The block does not judge whether recovery worked. A controller starts it with `recover_req` and waits for the one-cycle `done` pulse.

Top module: `i2c_unstick`

## Requirements
- R1: Out of reset, and at any time `busy` is low, `scl_oe` and `sda_oe` are both 0 and `busy` and `done` are low. An enable of 1 pulls its line low, and 0 releases it.
- R2: When no line is held by a target, `sda_oe` rises 9 ticks after the request is accepted, while `scl_oe` stays 0. This is a start condition. `scl_oe` then rises 7 ticks later.
- R3: 6 ticks after the start pulls the clock low, `sda_oe` falls. 3 ticks after that, `scl_oe` falls to begin the first clock pulse.
- R4: Exactly nine clock pulses follow. In each, the clock is released for 5 ticks (one poll plus 4 high) and then pulled low for 6 ticks. `sda_oe` stays 0 for all nine.
- R5: 9 ticks after the ninth pulse pulls the clock low, the clock is released. After another 6 ticks `sda_oe` rises, which is the second start. After another 7 ticks `scl_oe` rises.
- R6: 9 ticks after the second start pulls the clock low, the clock is released with data held low. After another 5 ticks `sda_oe` falls, which is the stop. Neither enable changes after that.
- R7: While the clock is released, `scl_in` is sampled at every tick. The step ends at the first tick that sees it high, so a target holding it low for K ticks stretches that phase by K ticks.
- R8: If `scl_in` is still low after 500 polls, the sequencer moves on anyway. That phase then lasts 499 ticks longer than an unstretched one.
- R9: A `recover_req` that arrives while `busy` is high has no effect: the waveform does not restart and no second `done` follows.
- R10: `done` is high for exactly one clock, 8 ticks after the stop releases data. `busy` falls on the same edge.
- R11: `scl_oe` and `sda_oe` change only on clock edges at which `us_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| recover_req | input | 1 | Start one recovery sequence; ignored while busy |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the bus-free time has elapsed |

## Verification
The bench measures the tick gap between successive line changes. A design that merged or dropped a setup, hold or settle wait would be off by a few ticks, and one that looped eight or ten times would shift every later event. A stretch is injected on one clock pulse, so a sequencer that ignored `scl_in` would finish that phase K ticks early. A clock line held low past the cap checks that a poll counter off by one moves the stop by one tick, and that a missing cap hangs the run. A request injected mid-sequence would show up as an extra waveform or a second `done` if it were latched.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

   typedef enum logic [1:0] {LN_KEEP = 2'd0, LN_LOW = 2'd1, LN_REL = 2'd2} line_act_e;

   typedef enum logic [2:0] {
      WT_DSET, WT_SU_STA, WT_HD_STA, WT_FALL, WT_LOW, WT_HIGH, WT_SU_STO, WT_BUF
   } wait_sel_e;

   typedef struct packed {
      line_act_e scl;
      line_act_e sda;
      logic      poll;
      wait_sel_e wsel;
   } step_t;

   localparam int PC_W = 5;
   localparam logic [PC_W-1:0] PC_START2   = 5'd12;
   localparam logic [PC_W-1:0] PC_LOOP_TOP = 5'd8;
   localparam logic [PC_W-1:0] PC_LOOP_END = 5'd11;
   localparam logic [PC_W-1:0] PC_LAST     = 5'd23;

   // Microprogram: each step sets the lines on entry, then waits.
   function automatic step_t step_at(logic [PC_W-1:0] pc);
      step_t s;
      logic [PC_W-1:0] k;
      s.scl  = LN_KEEP;
      s.sda  = LN_KEEP;
      s.poll = 1'b0;
      s.wsel = WT_DSET;
      k = (pc >= PC_START2 && pc <= PC_START2 + 5'd6) ? pc - PC_START2 : pc;
      case (k)
         5'd0:  s.sda  = LN_REL;
         5'd1:  begin s.scl = LN_REL; s.poll = 1'b1; end
         5'd2:  s.wsel = WT_SU_STA;
         5'd3:  s.sda  = LN_LOW;
         5'd4:  s.wsel = WT_HD_STA;
         5'd5:  begin s.scl = LN_LOW; s.wsel = WT_FALL; end
         5'd6:  s.wsel = WT_LOW;
         5'd7:  s.sda  = LN_REL;
         5'd8:  begin s.scl = LN_REL; s.poll = 1'b1; end
         5'd9:  s.wsel = WT_HIGH;
         5'd10: begin s.scl = LN_LOW; s.wsel = WT_FALL; end
         5'd11: s.wsel = WT_LOW;
         5'd19: s.sda  = LN_LOW;
         5'd20: begin s.scl = LN_REL; s.poll = 1'b1; end
         5'd21: s.wsel = WT_SU_STO;
         5'd22: s.sda  = LN_REL;
         5'd23: s.wsel = WT_BUF;
         default: ;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/i2crec_timer.sv
module i2crec_timer #(
   parameter int CNT_W    = 6,
   parameter int POLL_W   = 9,
   parameter int POLL_MAX = 500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             load_poll,
   input  logic             tick,
   input  logic             scl_in,
   output logic             fin
);
   logic [CNT_W-1:0]  cnt_q;
   logic [POLL_W-1:0] polls_q;
   logic              mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         polls_q <= '0;
         mode_q  <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_cnt;
         polls_q <= '0;
         mode_q  <= load_poll;
      end else if (tick) begin
         if (mode_q) polls_q <= polls_q + 1'b1;
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      if (mode_q) fin = tick && (scl_in || polls_q == POLL_W'(POLL_MAX - 1));
      else        fin = tick && (cnt_q == CNT_W'(1));
   end
endmodule

// File: rtl/i2crec_lines.sv
module i2crec_lines
   import i2crec_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      apply,
   input  line_act_e scl_act,
   input  line_act_e sda_act,
   output logic      scl_oe,
   output logic      sda_oe
);
   line_act_e act [2];
   logic      oe_q [2];

   assign act[0] = scl_act;
   assign act[1] = sda_act;

   for (genvar i = 0; i < 2; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          oe_q[i] <= 1'b0;
         else if (apply && act[i] == LN_LOW)  oe_q[i] <= 1'b1;
         else if (apply && act[i] == LN_REL)  oe_q[i] <= 1'b0;
      end
   end

   assign scl_oe = oe_q[0];
   assign sda_oe = oe_q[1];
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
   import i2crec_pkg::*;
#(
   parameter int T_DSET      = 3,
   parameter int T_SU_STA    = 5,
   parameter int T_HD_STA    = 4,
   parameter int T_FALL      = 1,
   parameter int T_LOW       = 5,
   parameter int T_HIGH      = 4,
   parameter int T_SU_STO    = 4,
   parameter int T_BUF       = 5,
   parameter int STRETCH_MAX = 500,
   parameter int N_PULSES    = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic us_tick,
   input  logic recover_req,
   input  logic scl_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic busy,
   output logic done
);
   localparam int WAIT_SUM = T_DSET + T_SU_STA + T_HD_STA + T_FALL + T_LOW
                             + T_HIGH + T_SU_STO + T_BUF;
   localparam int CNT_W  = $clog2(WAIT_SUM + 1);
   localparam int POLL_W = $clog2(STRETCH_MAX + 1);
   localparam int PUL_W  = $clog2(N_PULSES + 1);

   if (T_DSET < 1 || T_SU_STA < 1 || T_HD_STA < 1 || T_FALL < 1 ||
       T_LOW < 1 || T_HIGH < 1 || T_SU_STO < 1 || T_BUF < 1) begin : g_bad_wait
      $error("every wait must last at least one tick");
   end
   if (STRETCH_MAX < 1) begin : g_bad_stretch
      $error("stretch cap must allow one poll");
   end
   if (N_PULSES < 1) begin : g_bad_pulses
      $error("at least one recovery pulse is needed");
   end

   logic [PC_W-1:0]  pc_q, nxt_pc, ent_pc;
   logic [PUL_W-1:0] pulse_q;
   logic             busy_q, done_q;
   logic             accept, fin, enter, last, loop_back;
   step_t            ent_step;
   logic [CNT_W-1:0] ent_wait;

   assign accept    = !busy_q && recover_req;
   assign last      = (pc_q == PC_LAST);
   assign loop_back = (pc_q == PC_LOOP_END) && (pulse_q != PUL_W'(N_PULSES - 1));
   assign nxt_pc    = loop_back ? PC_LOOP_TOP : pc_q + 5'd1;
   assign enter     = accept || (busy_q && fin && !last);
   assign ent_pc    = accept ? '0 : nxt_pc;
   assign ent_step  = step_at(ent_pc);

   always_comb begin
      case (ent_step.wsel)
         WT_DSET:   ent_wait = CNT_W'(T_DSET);
         WT_SU_STA: ent_wait = CNT_W'(T_SU_STA);
         WT_HD_STA: ent_wait = CNT_W'(T_HD_STA);
         WT_FALL:   ent_wait = CNT_W'(T_FALL);
         WT_LOW:    ent_wait = CNT_W'(T_LOW);
         WT_HIGH:   ent_wait = CNT_W'(T_HIGH);
         WT_SU_STO: ent_wait = CNT_W'(T_SU_STO);
         default:   ent_wait = CNT_W'(T_BUF);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         pc_q    <= '0;
         pulse_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            pc_q    <= '0;
            pulse_q <= '0;
         end else if (busy_q && fin) begin
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               pc_q <= nxt_pc;
               if (pc_q == PC_LOOP_END) pulse_q <= pulse_q + 1'b1;
            end
         end
      end
   end

   i2crec_timer #(
      .CNT_W   (CNT_W),
      .POLL_W  (POLL_W),
      .POLL_MAX(STRETCH_MAX)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (enter),
      .load_cnt (ent_wait),
      .load_poll(ent_step.poll),
      .tick     (us_tick),
      .scl_in   (scl_in),
      .fin      (fin)
   );

   i2crec_lines u_lines (
      .clk    (clk),
      .rst_n  (rst_n),
      .apply  (enter),
      .scl_act(ent_step.scl),
      .sda_act(ent_step.sda),
      .scl_oe (scl_oe),
      .sda_oe (sda_oe)
   );

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
   parameter int N_PULSES = 9
) (
   input logic clk,
   input logic rst_n,
   input logic us_tick,
   input logic recover_req,
   input logic scl_oe,
   input logic sda_oe,
   input logic busy,
   input logic done
);
   int   rises_q;
   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rises_q <= 0;
         scl_q   <= 1'b0;
      end else begin
         scl_q <= scl_oe;
         if (!busy)               rises_q <= 0;
         else if (scl_oe && !scl_q) rises_q <= rises_q + 1;
      end
   end

   // R1
   idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   // R4
   pulse_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rises_q == N_PULSES + 2));

   // R9
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(recover_req));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11
   line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe != $past(scl_oe) || sda_oe != $past(sda_oe)) |-> $past(us_tick));
endmodule

bind i2c_unstick i2c_unstick_chk #(.N_PULSES(N_PULSES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .us_tick    (us_tick),
   .recover_req(recover_req),
   .scl_oe     (scl_oe),
   .sda_oe     (sda_oe),
   .busy       (busy),
   .done       (done)
);

// File: tb/sim_i2c_unstick.sv
module sim_i2c_unstick;
   localparam int T_DSET = 3, T_SU_STA = 5, T_HD_STA = 4, T_FALL = 1, T_LOW = 5;
   localparam int T_HIGH = 4, T_SU_STO = 4, T_BUF = 5, CAP = 500, NP = 9;
   localparam int TICK_DIV = 4;

   logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, recover_req = 1'b0;
   logic scl_oe, sda_oe, busy, done;
   int   hold = 0;
   wire  scl_in = !scl_oe && (hold == 0);

   typedef struct {
      bit    scl;
      bit    sda;
      bit    dn;
      int    gap;
      string tag;
   } ev_t;
   ev_t expq[$];

   int total = 0, bad = 0;
   int stretch_fall = 0, stretch_len = 0, falls = 0, gapcnt = 0, divc = 0;
   bit pscl = 0, psda = 0, pdn = 0, pbusy = 0, finished = 0;

   always #4 clk = ~clk;

   i2c_unstick u0 (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .recover_req(recover_req),
      .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done)
   );

   task automatic check(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(bit s, bit d, bit n, int g, string t);
      ev_t e;
      e.scl = s; e.sda = d; e.dn = n; e.gap = g; e.tag = t;
      expq.push_back(e);
   endtask

   // Driver side: expected line events for one recovery run.
   task automatic plan_run(int sfall, int sext);
      push(0, 1, 0, T_DSET + 1 + T_SU_STA, "R2");
      push(1, 1, 0, T_DSET + T_HD_STA, "R2");
      push(1, 0, 0, T_FALL + T_LOW, "R3");
      push(0, 0, 0, T_DSET, "R3");
      for (int p = 0; p < NP; p++) begin
         if (sfall == p + 1) push(1, 0, 0, 1 + T_HIGH + sext, "R7");
         else                push(1, 0, 0, 1 + T_HIGH, "R4");
         if (p < NP - 1) push(0, 0, 0, T_FALL + T_LOW, "R4");
      end
      push(0, 0, 0, T_FALL + T_LOW + T_DSET, "R5");
      push(0, 1, 0, 1 + T_SU_STA + ((sfall == NP + 1) ? sext : 0), "R5");
      push(1, 1, 0, T_DSET + T_HD_STA, "R5");
      push(0, 1, 0, T_FALL + T_LOW + T_DSET, "R6");
      if (sfall == NP + 2) push(0, 0, 0, 1 + T_SU_STO + sext, "R8");
      else                 push(0, 0, 0, 1 + T_SU_STO, "R6");
      push(0, 0, 1, T_DSET + T_BUF, "R10");
   endtask

   task automatic run(int sfall, int slen, int sext, bit poke);
      stretch_fall = sfall;
      stretch_len  = slen;
      plan_run(sfall, sext);
      @(negedge clk) recover_req = 1'b1;
      @(negedge clk) recover_req = 1'b0;
      if (poke) begin
         repeat (200) @(negedge clk);
         check(busy == 1'b1, "R9", "busy before second request", int'(busy), 1);
         recover_req = 1'b1;
         @(negedge clk) recover_req = 1'b0;
      end
      while (expq.size() != 0) @(negedge clk);
      repeat (60) @(negedge clk);
      check(busy == 1'b0, "R9", "busy after run", int'(busy), 0);
      check(done == 1'b0, "R10", "done after run", int'(done), 0);
      check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines after run",
            int'({scl_oe, sda_oe}), 0);
   endtask

   // Monitor: tick source, stretch injection and scoreboard compare.
   initial begin
      forever begin
         @(negedge clk);
         if (us_tick) begin
            gapcnt++;
            if (hold > 0) hold--;
         end
         if (rst_n && busy && !pbusy) begin
            gapcnt = 0; falls = 0; hold = 0;
         end
         if (rst_n && pscl && !scl_oe) begin
            falls++;
            if (falls == stretch_fall) hold = stretch_len;
         end
         if (rst_n && (scl_oe != pscl || sda_oe != psda || (done && !pdn))) begin
            check(us_tick == 1'b1, "R11", "line change off tick", int'(us_tick), 1);
            if (expq.size() == 0) begin
               check(1'b0, "R9", "unexpected line event", int'({scl_oe, sda_oe, done}), -1);
            end else begin
               ev_t e;
               e = expq.pop_front();
               check(scl_oe == e.scl && sda_oe == e.sda && done == e.dn, e.tag,
                     "line state", int'({scl_oe, sda_oe, done}), int'({e.scl, e.sda, e.dn}));
               check(gapcnt == e.gap, e.tag, "tick gap", gapcnt, e.gap);
               if (done) check(busy == 1'b0, "R10", "busy with done", int'(busy), 0);
            end
            gapcnt = 0;
         end
         pscl = scl_oe; psda = sda_oe; pdn = done; pbusy = busy;
         divc = (divc == TICK_DIV - 1) ? 0 : divc + 1;
         us_tick = (divc == 0);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "enables in reset",
            int'({scl_oe, sda_oe}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset",
            int'({busy, done}), 0);
      check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "enables after reset",
            int'({scl_oe, sda_oe}), 0);
      run(0, 0, 0, 1'b1);       // plain run plus an ignored request (R9)
      run(3, 7, 7, 1'b0);       // stretch on third pulse (R7)
      run(NP + 2, 600, CAP - 1, 1'b0);  // stop release held past cap (R8)
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule